// File: doc/BRIEF.md
# Register-Programmed Pad Multiplexer

This block decides, for each of 99 bidirectional pads, which on-chip source drives the pad's output and output-enable. It also decides which pad each on-chip consumer listens to. Three routing layers share the pads:

- fixed function groups that take over predetermined pad sets;
- a full crossbar that can steer any of 120 peripheral signals onto any of the 64 pads numbered 8 to 71;
- a per-pad mode that gives the pad to an I/O processor or to plain GPIO.

Software programs all of this through a small synchronous write port with a combinational read-back. One select register exists per peripheral signal, one mode register per pad, one group register, and one sticky conflict flag.

On the pad side the block presents output, output-enable and input vectors. On the peripheral side it presents matching vectors for the crossbar signals, the group signals, the I/O processor and GPIO. Only the registers are sequential. Every routing path, in either direction, is combinational from the register outputs.

Top module: `pmx_top`

## Requirements
- R1: While reset is low and after it: every select, mode and group field is zero and the conflict flag is clear. As a result every pad has `pad_o` = 0 and `pad_oe` = 0, every `per_i` bit is 1, and every read returns 0.
- R2: Crossbar select register of signal s is at address s (0..119) and holds a 7-bit value N. With N in 1..64, pad N+7 carries `per_o[s]` and `per_oe[s]`. For example, N=3 gives pad 10 and N=20 gives pad 27.
- R3: A select value of 0, or any value from 65 to 127, leaves the signal unrouted. It drives no pad, and its `per_i` bit reads 1.
- R4: Group register at address 240 holds the flash select in bits [1:0]. Value 1 puts group bits 0..3 on pads 83, 84, 86, 87. Value 2 puts them on pads 76, 78, 79, 81. Value 3 claims nothing.
- R5: Bit 2 of address 240 puts group bit 4 on pad 88 and group bit 5 on pad 89. Bit 3 puts group bits 6..15 on pads 72..81. Where the flash group and this ten-pad group share a pad, the flash group drives it.
- R6: Mode register of pad p is at address 128+p and holds 2 bits: 1 = I/O processor, 2 = GPIO, 0 or 3 = shared. Per pad, priority is I/O processor, then GPIO, then active groups, then crossbar. A shared pad with nothing routed is undriven.
- R7: If several signals select the same pad, the lowest signal index drives it. The conflict flag (address 241, bit 0) sets on the clock edge after a clash first exists. It then stays set until any write to address 241. A clash still present at that write keeps it set.
- R8: Input fan-back works as follows:
  - A routed `per_i[s]` equals `pad_i` of its pad.
  - A group input bit equals `pad_i` of its listed pad while that group is enabled, and is 1 otherwise.
  - `iop_i` and `gpio_i` always equal `pad_i`.
- R9: A write changes state at the next rising edge and not before. Reads return the stored field zero-extended. Unmapped addresses read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data at `reg_addr` |
| per_o | input | 120 | Crossbar peripheral output values |
| per_oe | input | 120 | Crossbar peripheral output enables |
| per_i | output | 120 | Crossbar peripheral input values |
| grp_o | input | 16 | Function-group output values |
| grp_oe | input | 16 | Function-group output enables |
| grp_i | output | 16 | Function-group input values |
| iop_o | input | 99 | I/O processor output per pad |
| iop_oe | input | 99 | I/O processor output enable per pad |
| iop_i | output | 99 | I/O processor input per pad |
| gpio_o | input | 99 | GPIO output per pad |
| gpio_oe | input | 99 | GPIO output enable per pad |
| gpio_i | output | 99 | GPIO input per pad |
| pad_o | output | 99 | Pad output value |
| pad_oe | output | 99 | Pad output enable |
| pad_i | input | 99 | Pad input value |

## Verification
A register write issued before a rising edge shows up on `pad_o`, `pad_oe`, `per_i`, `grp_i` and the read-back immediately after that same edge, because everything past the registers is combinational. The conflict flag is the one result that lags by a further edge. The bench therefore drives stimulus on falling edges and samples 2 ns after each rising edge. It updates its reference model on the same rising edge. A directed check confirms the flag is still clear in the cycle between the clashing write and the flag edge, and set after it.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
   localparam int ADDR_W    = 8;
   localparam int DATA_W    = 8;
   localparam int MODE_BASE = 128;
   localparam int GRP_ADDR  = 240;
   localparam int FLAG_ADDR = 241;

   typedef enum logic [1:0] {
      PM_SHARED     = 2'd0,
      PM_IOP        = 2'd1,
      PM_GPIO       = 2'd2,
      PM_SHARED_ALT = 2'd3
   } pad_mode_e;

   // group-side bit layout
   localparam int GRP_W    = 16;
   localparam int GB_FLASH = 0;
   localparam int GB_UART  = 4;
   localparam int GB_CARD  = 6;

   localparam int FLASH_N     = 4;
   localparam int CARD_PAD0   = 72;
   localparam int CARD_N      = 10;
   localparam int UART_TX_PAD = 88;
   localparam int UART_RX_PAD = 89;
   localparam int FLASH_PADS_A [FLASH_N] = '{83, 84, 86, 87};
   localparam int FLASH_PADS_B [FLASH_N] = '{76, 78, 79, 81};
endpackage

// File: rtl/pmx_regs.sv
module pmx_regs
   import pmx_pkg::*;
#(
   parameter int NUM_SIGS = 120,
   parameter int NUM_PADS = 99,
   parameter int SEL_W    = 7
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              reg_we,
   input  logic [ADDR_W-1:0]                 reg_addr,
   input  logic [DATA_W-1:0]                 reg_wdata,
   output logic [DATA_W-1:0]                 reg_rdata,
   input  logic                              dup,
   output logic [NUM_SIGS-1:0][SEL_W-1:0]    sel_q,
   output logic [NUM_PADS-1:0][1:0]          mode_q,
   output logic [1:0]                        flash_q,
   output logic                              uart_q,
   output logic                              card_q,
   output logic                              conflict_q
);
   if (NUM_SIGS > MODE_BASE) begin : g_bad_sigs
      $error("pmx_regs: NUM_SIGS overlaps the mode window");
   end
   if (MODE_BASE + NUM_PADS > GRP_ADDR) begin : g_bad_pads
      $error("pmx_regs: NUM_PADS overlaps the group register");
   end
   if (SEL_W > DATA_W) begin : g_bad_sel
      $error("pmx_regs: select field wider than data bus");
   end

   logic clr_flag;
   logic unused_wdata_bits;
   assign clr_flag          = reg_we && (reg_addr == ADDR_W'(FLAG_ADDR));
   assign unused_wdata_bits = ^reg_wdata[DATA_W-1:4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q      <= '0;
         mode_q     <= '0;
         flash_q    <= '0;
         uart_q     <= 1'b0;
         card_q     <= 1'b0;
         conflict_q <= 1'b0;
      end else begin
         for (int i = 0; i < NUM_SIGS; i++)
            if (reg_we && reg_addr == ADDR_W'(i)) sel_q[i] <= reg_wdata[SEL_W-1:0];
         for (int i = 0; i < NUM_PADS; i++)
            if (reg_we && reg_addr == ADDR_W'(MODE_BASE + i)) mode_q[i] <= reg_wdata[1:0];
         if (reg_we && reg_addr == ADDR_W'(GRP_ADDR)) begin
            flash_q <= reg_wdata[1:0];
            uart_q  <= reg_wdata[2];
            card_q  <= reg_wdata[3];
         end
         conflict_q <= dup | (conflict_q & ~clr_flag);
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_SIGS; i++)
         if (reg_addr == ADDR_W'(i)) reg_rdata = DATA_W'(sel_q[i]);
      for (int i = 0; i < NUM_PADS; i++)
         if (reg_addr == ADDR_W'(MODE_BASE + i)) reg_rdata = DATA_W'(mode_q[i]);
      if (reg_addr == ADDR_W'(GRP_ADDR))  reg_rdata = DATA_W'({card_q, uart_q, flash_q});
      if (reg_addr == ADDR_W'(FLAG_ADDR)) reg_rdata = DATA_W'(conflict_q);
   end
endmodule

// File: rtl/pmx_xbar.sv
module pmx_xbar #(
   parameter int NUM_SIGS  = 120,
   parameter int XBAR_PADS = 64,
   parameter int SEL_W     = 7,
   parameter int IDX_W     = 6
) (
   input  logic [NUM_SIGS-1:0][SEL_W-1:0] sel,
   input  logic [NUM_SIGS-1:0]            per_o,
   input  logic [NUM_SIGS-1:0]            per_oe,
   output logic [NUM_SIGS-1:0]            per_i,
   input  logic [XBAR_PADS-1:0]           xpad_i,
   output logic [XBAR_PADS-1:0]           xb_hit,
   output logic [XBAR_PADS-1:0]           xb_o,
   output logic [XBAR_PADS-1:0]           xb_oe,
   output logic                           dup
);
   logic [XBAR_PADS-1:0] many;

   // per pad: lowest-index selector wins, any second selector marks a clash
   for (genvar j = 0; j < XBAR_PADS; j++) begin : g_xpad
      logic hit, o, oe, mny;
      always_comb begin
         hit = 1'b0;
         o   = 1'b0;
         oe  = 1'b0;
         mny = 1'b0;
         for (int s = 0; s < NUM_SIGS; s++) begin
            if (sel[s] == SEL_W'(j + 1)) begin
               if (hit) begin
                  mny = 1'b1;
               end else begin
                  hit = 1'b1;
                  o   = per_o[s];
                  oe  = per_oe[s];
               end
            end
         end
      end
      assign xb_hit[j] = hit;
      assign xb_o[j]   = o;
      assign xb_oe[j]  = oe;
      assign many[j]   = mny;
   end

   assign dup = |many;

   // per signal: fan the selected pad back, idle high when unrouted
   for (genvar s = 0; s < NUM_SIGS; s++) begin : g_sig
      logic             routed;
      logic [IDX_W-1:0] ix;
      assign routed   = (sel[s] != '0) && (sel[s] <= SEL_W'(XBAR_PADS));
      assign ix       = IDX_W'(sel[s] - SEL_W'(1));
      assign per_i[s] = routed ? xpad_i[ix] : 1'b1;
   end
endmodule

// File: rtl/pmx_groups.sv
module pmx_groups
   import pmx_pkg::*;
#(
   parameter int NUM_PADS = 99
) (
   input  logic [1:0]          flash_sel,
   input  logic                uart_en,
   input  logic                card_en,
   input  logic [GRP_W-1:0]    grp_o,
   input  logic [GRP_W-1:0]    grp_oe,
   output logic [GRP_W-1:0]    grp_i,
   input  logic [NUM_PADS-1:0] pad_i,
   output logic [NUM_PADS-1:0] claim,
   output logic [NUM_PADS-1:0] cl_o,
   output logic [NUM_PADS-1:0] cl_oe
);
   if (NUM_PADS <= UART_RX_PAD) begin : g_bad_pads
      $error("pmx_groups: pad count too small for the fixed groups");
   end

   // later assignments override earlier ones: flash outranks the card group
   always_comb begin
      claim = '0;
      cl_o  = '0;
      cl_oe = '0;
      grp_i = '1;
      if (card_en) begin
         for (int k = 0; k < CARD_N; k++) begin
            claim[CARD_PAD0+k]   = 1'b1;
            cl_o[CARD_PAD0+k]    = grp_o[GB_CARD+k];
            cl_oe[CARD_PAD0+k]   = grp_oe[GB_CARD+k];
            grp_i[GB_CARD+k]     = pad_i[CARD_PAD0+k];
         end
      end
      if (uart_en) begin
         claim[UART_TX_PAD]   = 1'b1;
         cl_o[UART_TX_PAD]    = grp_o[GB_UART];
         cl_oe[UART_TX_PAD]   = grp_oe[GB_UART];
         grp_i[GB_UART]       = pad_i[UART_TX_PAD];
         claim[UART_RX_PAD]   = 1'b1;
         cl_o[UART_RX_PAD]    = grp_o[GB_UART+1];
         cl_oe[UART_RX_PAD]   = grp_oe[GB_UART+1];
         grp_i[GB_UART+1]     = pad_i[UART_RX_PAD];
      end
      for (int k = 0; k < FLASH_N; k++) begin
         if (flash_sel == 2'd1) begin
            claim[FLASH_PADS_A[k]] = 1'b1;
            cl_o[FLASH_PADS_A[k]]  = grp_o[GB_FLASH+k];
            cl_oe[FLASH_PADS_A[k]] = grp_oe[GB_FLASH+k];
            grp_i[GB_FLASH+k]      = pad_i[FLASH_PADS_A[k]];
         end else if (flash_sel == 2'd2) begin
            claim[FLASH_PADS_B[k]] = 1'b1;
            cl_o[FLASH_PADS_B[k]]  = grp_o[GB_FLASH+k];
            cl_oe[FLASH_PADS_B[k]] = grp_oe[GB_FLASH+k];
            grp_i[GB_FLASH+k]      = pad_i[FLASH_PADS_B[k]];
         end
      end
   end
endmodule

// File: rtl/pmx_top.sv
module pmx_top
   import pmx_pkg::*;
#(
   parameter int NUM_PADS  = 99,
   parameter int NUM_SIGS  = 120,
   parameter int XBAR_BASE = 8,
   parameter int XBAR_PADS = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [7:0]          reg_addr,
   input  logic [7:0]          reg_wdata,
   output logic [7:0]          reg_rdata,
   input  logic [NUM_SIGS-1:0] per_o,
   input  logic [NUM_SIGS-1:0] per_oe,
   output logic [NUM_SIGS-1:0] per_i,
   input  logic [15:0]         grp_o,
   input  logic [15:0]         grp_oe,
   output logic [15:0]         grp_i,
   input  logic [NUM_PADS-1:0] iop_o,
   input  logic [NUM_PADS-1:0] iop_oe,
   output logic [NUM_PADS-1:0] iop_i,
   input  logic [NUM_PADS-1:0] gpio_o,
   input  logic [NUM_PADS-1:0] gpio_oe,
   output logic [NUM_PADS-1:0] gpio_i,
   output logic [NUM_PADS-1:0] pad_o,
   output logic [NUM_PADS-1:0] pad_oe,
   input  logic [NUM_PADS-1:0] pad_i
);
   localparam int SEL_W = $clog2(XBAR_PADS + 1);
   localparam int IDX_W = $clog2(XBAR_PADS);

   if (XBAR_BASE + XBAR_PADS > NUM_PADS) begin : g_bad_range
      $error("pmx_top: crossbar window runs past the last pad");
   end

   logic [NUM_SIGS-1:0][SEL_W-1:0] sel_q;
   logic [NUM_PADS-1:0][1:0]       mode_q;
   logic [1:0]                     flash_q;
   logic                           uart_q, card_q, conflict_q, xb_dup;
   logic [XBAR_PADS-1:0]           xb_hit, xb_o, xb_oe;
   logic [NUM_PADS-1:0]            claim, cl_o, cl_oe;

   pmx_regs #(.NUM_SIGS(NUM_SIGS), .NUM_PADS(NUM_PADS), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dup(xb_dup),
      .sel_q(sel_q), .mode_q(mode_q), .flash_q(flash_q), .uart_q(uart_q),
      .card_q(card_q), .conflict_q(conflict_q)
   );

   pmx_xbar #(.NUM_SIGS(NUM_SIGS), .XBAR_PADS(XBAR_PADS), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_xbar (
      .sel(sel_q), .per_o(per_o), .per_oe(per_oe), .per_i(per_i),
      .xpad_i(pad_i[XBAR_BASE +: XBAR_PADS]),
      .xb_hit(xb_hit), .xb_o(xb_o), .xb_oe(xb_oe), .dup(xb_dup)
   );

   pmx_groups #(.NUM_PADS(NUM_PADS)) u_grp (
      .flash_sel(flash_q), .uart_en(uart_q), .card_en(card_q),
      .grp_o(grp_o), .grp_oe(grp_oe), .grp_i(grp_i), .pad_i(pad_i),
      .claim(claim), .cl_o(cl_o), .cl_oe(cl_oe)
   );

   assign iop_i  = pad_i;
   assign gpio_i = pad_i;

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      logic xhit, xo, xoe;
      if (p >= XBAR_BASE && p < XBAR_BASE + XBAR_PADS) begin : g_xb
         assign xhit = xb_hit[p-XBAR_BASE];
         assign xo   = xb_o[p-XBAR_BASE];
         assign xoe  = xb_oe[p-XBAR_BASE];
      end else begin : g_fixed
         assign xhit = 1'b0;
         assign xo   = 1'b0;
         assign xoe  = 1'b0;
      end
      always_comb begin
         if (pad_mode_e'(mode_q[p]) == PM_IOP) begin
            pad_o[p] = iop_o[p];   pad_oe[p] = iop_oe[p];
         end else if (pad_mode_e'(mode_q[p]) == PM_GPIO) begin
            pad_o[p] = gpio_o[p];  pad_oe[p] = gpio_oe[p];
         end else if (claim[p]) begin
            pad_o[p] = cl_o[p];    pad_oe[p] = cl_oe[p];
         end else if (xhit) begin
            pad_o[p] = xo;         pad_oe[p] = xoe;
         end else begin
            pad_o[p] = 1'b0;       pad_oe[p] = 1'b0;
         end
      end
   end
endmodule

// File: rtl/pmx_chk.sv
module pmx_chk
   import pmx_pkg::*;
#(
   parameter int NUM_PADS  = 99,
   parameter int NUM_SIGS  = 120,
   parameter int XBAR_PADS = 64,
   parameter int SEL_W     = 7
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           reg_we,
   input logic [7:0]                     reg_addr,
   input logic [7:0]                     reg_wdata,
   input logic [NUM_SIGS-1:0][SEL_W-1:0] sel_q,
   input logic [NUM_PADS-1:0][1:0]       mode_q,
   input logic [3:0]                     grp_q,
   input logic                           conflict_q,
   input logic                           xb_dup,
   input logic [NUM_SIGS-1:0]            per_i,
   input logic [NUM_PADS-1:0]            pad_o,
   input logic [NUM_PADS-1:0]            pad_oe,
   input logic [NUM_PADS-1:0]            iop_o,
   input logic [NUM_PADS-1:0]            iop_oe
);
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (pad_oe == '0 && !conflict_q);
      end
   end

   assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conflict_q) |-> $past(xb_dup));

   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (conflict_q && !(reg_we && reg_addr == 8'(FLAG_ADDR))) |=> conflict_q);

   assert_group_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 8'(GRP_ADDR)) |=> (grp_q == $past(reg_wdata[3:0])));

   for (genvar s = 0; s < NUM_SIGS; s++) begin : g_sig_chk
      assert_idle_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_q[s] == '0 || sel_q[s] > SEL_W'(XBAR_PADS)) |-> per_i[s]);
   end

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad_chk
      assert_iop_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q[p] == 2'd1) |-> (pad_o[p] == iop_o[p] && pad_oe[p] == iop_oe[p]));
   end
endmodule

bind pmx_top pmx_chk #(
   .NUM_PADS(NUM_PADS), .NUM_SIGS(NUM_SIGS), .XBAR_PADS(XBAR_PADS), .SEL_W(SEL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .sel_q(sel_q), .mode_q(mode_q), .grp_q({card_q, uart_q, flash_q}),
   .conflict_q(conflict_q), .xb_dup(xb_dup), .per_i(per_i),
   .pad_o(pad_o), .pad_oe(pad_oe), .iop_o(iop_o), .iop_oe(iop_oe)
);

// File: tb/sim_pmx_top.sv
`timescale 1ns/1ps
module sim_pmx_top;
   localparam int NP = 99, NS = 120;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0, we = 1'b0;
   logic [7:0] addr = '0, wdata = '0;
   wire  [7:0] rdata;
   logic [NS-1:0] per_o = '0, per_oe = '0;
   wire  [NS-1:0] per_i;
   logic [15:0] grp_o = '0, grp_oe = '0;
   wire  [15:0] grp_i;
   logic [NP-1:0] iop_o = '0, iop_oe = '0, gpio_o = '0, gpio_oe = '0, pad_i = '0;
   wire  [NP-1:0] iop_i, gpio_i, pad_o, pad_oe;

   pmx_top u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .per_o(per_o), .per_oe(per_oe), .per_i(per_i),
      .grp_o(grp_o), .grp_oe(grp_oe), .grp_i(grp_i),
      .iop_o(iop_o), .iop_oe(iop_oe), .iop_i(iop_i),
      .gpio_o(gpio_o), .gpio_oe(gpio_oe), .gpio_i(gpio_i),
      .pad_o(pad_o), .pad_oe(pad_oe), .pad_i(pad_i)
   );

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // reference state
   int m_sel[NS];
   int m_mode[NP];
   int m_flash = 0, m_uart = 0, m_card = 0, m_flag = 0;

   function automatic int clash_now();
      int cnt[64];
      foreach (cnt[j]) cnt[j] = 0;
      foreach (m_sel[s]) if (m_sel[s] >= 1 && m_sel[s] <= 64) cnt[m_sel[s]-1]++;
      foreach (cnt[j]) if (cnt[j] > 1) return 1;
      return 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_sel[s]) m_sel[s] = 0;
         foreach (m_mode[p]) m_mode[p] = 0;
         m_flash = 0; m_uart = 0; m_card = 0; m_flag = 0;
      end else begin
         int d;
         d = clash_now();
         m_flag = (d != 0 || (m_flag != 0 && !(we && addr == 241))) ? 1 : 0;
         if (we) begin
            if (addr < NS) m_sel[addr] = wdata & 127;
            else if (addr >= 128 && addr < 128 + NP) m_mode[addr-128] = wdata & 3;
            else if (addr == 240) begin
               m_flash = wdata & 3; m_uart = (wdata >> 2) & 1; m_card = (wdata >> 3) & 1;
            end
         end
      end
   end

   logic [NP-1:0] e_o, e_oe;
   string e_tag[NP];
   logic [NS-1:0] e_pi;
   logic [15:0] e_gi;
   logic [7:0] e_rd;

   task automatic compute_expect();
      int gmap[NP];
      int fa[4] = '{83, 84, 86, 87};
      int fb[4] = '{76, 78, 79, 81};
      foreach (gmap[p]) gmap[p] = -1;
      e_gi = '1;
      if (m_card) for (int k = 0; k < 10; k++) begin gmap[72+k] = 6 + k; e_gi[6+k] = pad_i[72+k]; end
      if (m_uart) begin gmap[88] = 4; gmap[89] = 5; e_gi[4] = pad_i[88]; e_gi[5] = pad_i[89]; end
      for (int k = 0; k < 4; k++) begin
         if (m_flash == 1) begin gmap[fa[k]] = k; e_gi[k] = pad_i[fa[k]]; end
         if (m_flash == 2) begin gmap[fb[k]] = k; e_gi[k] = pad_i[fb[k]]; end
      end
      for (int p = 0; p < NP; p++) begin
         e_o[p] = 1'b0; e_oe[p] = 1'b0; e_tag[p] = "R3";
         if (m_mode[p] == 1) begin e_o[p] = iop_o[p]; e_oe[p] = iop_oe[p]; e_tag[p] = "R6"; end
         else if (m_mode[p] == 2) begin e_o[p] = gpio_o[p]; e_oe[p] = gpio_oe[p]; e_tag[p] = "R6"; end
         else if (gmap[p] >= 0) begin
            e_o[p] = grp_o[gmap[p]]; e_oe[p] = grp_oe[gmap[p]];
            e_tag[p] = (gmap[p] < 4) ? "R4" : "R5";
         end else if (p >= 8 && p < 72) begin
            int n = 0;
            for (int s = NS - 1; s >= 0; s--)
               if (m_sel[s] == p - 7) begin e_o[p] = per_o[s]; e_oe[p] = per_oe[s]; n++; end
            if (n > 0) e_tag[p] = (n > 1) ? "R7" : "R2";
         end
      end
      for (int s = 0; s < NS; s++)
         e_pi[s] = (m_sel[s] >= 1 && m_sel[s] <= 64) ? pad_i[m_sel[s] + 7] : 1'b1;
      e_rd = 8'h00;
      if (addr < NS) e_rd = 8'(m_sel[addr]);
      else if (addr >= 128 && addr < 128 + NP) e_rd = 8'(m_mode[addr-128]);
      else if (addr == 240) e_rd = 8'(m_card * 8 + m_uart * 4 + m_flash);
      else if (addr == 241) e_rd = 8'(m_flag);
   endtask

   task automatic compare_all();
      compute_expect();
      checks++;
      if (pad_o !== e_o || pad_oe !== e_oe) begin
         fails++;
         for (int p = 0; p < NP; p++)
            if (pad_o[p] !== e_o[p] || pad_oe[p] !== e_oe[p]) begin
               $display("FAIL %s pad %0d o/oe actual %b%b expected %b%b", e_tag[p], p,
                        pad_o[p], pad_oe[p], e_o[p], e_oe[p]);
               break;
            end
      end
      checks++;
      if (per_i !== e_pi) begin
         fails++;
         $display("FAIL R8 per_i actual %h expected %h", per_i, e_pi);
      end
      checks++;
      if (grp_i !== e_gi || iop_i !== pad_i || gpio_i !== pad_i) begin
         fails++;
         $display("FAIL R8 grp_i actual %h expected %h (iop_i/gpio_i vs pad_i %b%b)", grp_i, e_gi,
                  iop_i === pad_i, gpio_i === pad_i);
      end
      checks++;
      if (rdata !== e_rd) begin
         fails++;
         $display("FAIL R9 rdata at %0d actual %h expected %h", addr, rdata, e_rd);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (!done) compare_all();
   end

   task automatic chk(input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %b expected %b", what, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      we = 1'b1; addr = 8'(a); wdata = 8'(d);
      @(negedge clk);
      we = 1'b0;
      #1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(|pad_oe, 1'b0, "R1 pad_oe in reset");
      chk(&per_i, 1'b1, "R1 per_i idle in reset");
      chk(|rdata, 1'b0, "R1 rdata in reset");
      @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < NP; i++) begin
         iop_o[i] = $urandom % 2; iop_oe[i] = $urandom % 2;
         gpio_o[i] = $urandom % 2; gpio_oe[i] = 1'b1;
      end
      per_o[5] = 1'b1; per_oe[5] = 1'b1; per_o[7] = 1'b0; per_oe[7] = 1'b1;
      pad_i[27] = 1'b0;
      wr(5, 3);
      chk(pad_o[10], 1'b1, "R2 sel 3 drives pad 10 value");
      chk(pad_oe[10], 1'b1, "R2 sel 3 drives pad 10 enable");
      wr(7, 20);
      chk(pad_oe[27], 1'b1, "R2 sel 20 drives pad 27");
      chk(per_i[7], 1'b0, "R8 per_i follows pad 27");
      pad_i[72] = 1'b0;
      wr(9, 65);
      chk(per_i[9], 1'b1, "R3 sel 65 input idle");
      chk(pad_oe[72], 1'b0, "R3 sel 65 drives nothing");
      chk(rdata == 8'd65, 1'b1, "R9 readback of sel 9");
      // clash: signals 2 and 40 both choose pad 37
      per_o[2] = 1'b0; per_oe[2] = 1'b1; per_o[40] = 1'b1; per_oe[40] = 1'b1;
      wr(2, 30);
      addr = 8'd241;
      wr(40, 30);
      addr = 8'd241; #1;
      chk(pad_o[37], 1'b0, "R7 lower index drives pad 37");
      chk(rdata[0], 1'b0, "R7 flag not yet set");
      @(posedge clk); #2;
      chk(rdata[0], 1'b1, "R7 flag set one edge later");
      wr(40, 0);
      addr = 8'd241; @(posedge clk); #2;
      chk(rdata[0], 1'b1, "R7 flag sticky");
      wr(241, 0);
      chk(rdata[0], 1'b0, "R7 flag cleared by write");
      // groups
      grp_o = 16'hA5C3; grp_oe = 16'hFFFF;
      wr(240, 1);
      chk(pad_o[86], grp_o[2], "R4 flash 1 pad 86");
      chk(pad_oe[83], 1'b1, "R4 flash 1 pad 83");
      wr(240, 2);
      chk(pad_o[81], grp_o[3], "R4 flash 2 pad 81");
      chk(pad_oe[83], 1'b0, "R4 flash 2 releases 83");
      wr(240, 3);
      chk(pad_oe[76] | pad_oe[83], 1'b0, "R4 flash 3 claims nothing");
      wr(240, 12);
      chk(pad_o[88], grp_o[4], "R5 uart tx pad 88");
      chk(pad_o[77], grp_o[11], "R5 card pad 77");
      wr(240, 10);
      chk(pad_o[76], grp_o[0], "R5 flash outranks card on 76");
      // pad modes
      wr(128 + 10, 1);
      chk(pad_oe[10], iop_oe[10], "R6 iop mode pad 10");
      wr(128 + 10, 2);
      chk(pad_o[10], gpio_o[10], "R6 gpio mode pad 10");
      wr(128 + 72, 2);
      chk(pad_o[72], gpio_o[72], "R6 gpio outranks group on 72");
      wr(128 + 10, 3);
      chk(pad_o[10], 1'b1, "R6 mode 3 returns pad 10 to crossbar");
      wr(124, 55);
      chk(|rdata, 1'b0, "R9 unmapped address reads 0");
      // random phase, checked every cycle against the model
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         for (int i = 0; i < NS; i++) begin per_o[i] = $urandom % 2; per_oe[i] = $urandom % 2; end
         for (int i = 0; i < NP; i++) begin
            pad_i[i] = $urandom % 2; iop_o[i] = $urandom % 2; gpio_o[i] = $urandom % 2;
         end
         grp_o = 16'($urandom); grp_oe = 16'($urandom);
         we = ($urandom % 3 == 0);
         case ($urandom % 10)
            0, 1, 2, 3, 4: begin addr = 8'($urandom % NS); wdata = 8'($urandom % 72); end
            5, 6, 7: begin
               addr = 8'(128 + $urandom % NP);
               wdata = ($urandom % 4 == 0) ? 8'($urandom % 4) : 8'd0;
            end
            8: begin addr = 8'd240; wdata = 8'($urandom % 16); end
            default: begin addr = 8'($urandom); wdata = 8'($urandom); end
         endcase
      end
      @(negedge clk); we = 1'b0;
      @(posedge clk); #3;
      finish_run();
   end
endmodule